// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. A start pulse arrives when the serial interface finishes a frame. The block then captures the 4-bit channel code, drives the analog multiplexer select, and holds a track window so that the sample capacitor can charge. After that it walks a trial word from the most significant bit down to the least significant bit. The comparator and DAC sit outside the block and return a single bit: high when the selected input is at or above the current trial word.

Each conversion occupies a fixed frame of 20 clock cycles. The frame has two track cycles, eight bit-decision cycles and idle padding, and ends in one result-load edge. On that edge the final code moves into a holding register, and the end-of-conversion flag rises on the same edge. The serial interface shifts the next frame out of this register. An abort input ends any conversion in progress, leaves the holding register as it was, and returns the sequencer to idle.

Top module: `sar_conv_seq`

## Requirements
- R1: After synchronous reset, eoc_o is 1 and result_o, trial_o and mux_sel_o are 0. track_o is 0.
- R2: While idle, a start_i sampled high with abort_i low captures chan_i. Codes 0x0 to 0xA appear unchanged on mux_sel_o from the edge that accepts the start.
- R3: Channel codes 0xB to 0xF all drive mux_sel_o to 0xB, which selects the internal mid-scale test level. With a healthy comparator path that channel converts to 0x80.
- R4: eoc_o falls on the edge that accepts a start. It rises on the 20th edge after that one, and result_o takes the new code on that same edge.
- R5: The result is the largest code that the comparator reports at or below the input. An input at the upper reference gives 0xFF and an input at the lower reference gives 0x00.
- R6: track_o is high for the first two frame cycles after the start edge. trial_o then shows 0x80 for one cycle. In each following cycle it shows the previous trial with the bit under test kept when cmp_ge_i was 1 (cleared when it was 0), and with the next lower bit set.
- R7: A start_i pulse while a conversion is running has no effect. mux_sel_o, the end-of-conversion timing and the result are those of the running conversion.
- R8: abort_i sampled high stops any conversion. On the next cycle eoc_o is 1, trial_o is 0 and result_o is unchanged. When abort_i and start_i are high together, the abort wins and no conversion starts.
- R9: result_o changes only on a result-load edge. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the serial interface |
| chan_i | input | 4 | Channel code captured at start |
| abort_i | input | 1 | Interface reset; ends the current conversion |
| cmp_ge_i | input | 1 | Comparator: selected input is at or above trial_o |
| mux_sel_o | output | 4 | Analog multiplexer select (0xB = test level) |
| track_o | output | 1 | Sample-and-hold tracking window |
| trial_o | output | 8 | Trial word presented to the DAC |
| result_o | output | 8 | Holding register with the last completed code |
| eoc_o | output | 1 | End of conversion; low while converting |

## Verification
The bench drives the two ends of the full-scale range. A design that mishandled the least significant decision or the first trial would return 0xFE or 0x01 instead of 0xFF or 0x00. It converts the test channel through both its direct code and an out-of-range code. A design that passed 0xC to 0xF straight to the multiplexer would select a missing input and return a wrong code. Starts are injected in the middle of a frame and on its last busy cycle. A sequencer that re-armed early would change the select or stretch the frame. Aborts, including one that arrives together with a start, must leave the old result in place. A design that wrote the partial trial word, or that let the start win, would disturb the holding register or pull eoc_o low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W  = 8;
    localparam int CHAN_W = 4;
    localparam int IDX_W  = $clog2(RES_W);

    typedef logic [RES_W-1:0]  code_t;
    typedef logic [CHAN_W-1:0] chan_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACQ,
        PH_TRIAL,
        PH_PAD
    } phase_e;

    // One frame step, decoded from the frame counter.
    typedef struct packed {
        logic             init;    // load MSB trial on this edge
        logic             decide;  // resolve bit idx on this edge
        logic [IDX_W-1:0] idx;     // bit being resolved
        logic             load;    // move trial word to holding register
    } step_t;

    function automatic chan_t map_chan(chan_t code, chan_t last_in, chan_t test_code);
        return (code > last_in) ? test_code : code;
    endfunction

    function automatic code_t bit_mask(logic [IDX_W-1:0] pos);
        return code_t'(1) << pos;
    endfunction

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
    import sar_seq_pkg::*;
#(
    parameter int ACQ_CYCLES   = 2,
    parameter int FRAME_CYCLES = 20
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   go_i,
    input  logic   abort_i,
    output logic   busy_o,
    output phase_e phase_o,
    output step_t  step_o
);

    localparam int CNT_W      = $clog2(FRAME_CYCLES);
    localparam int TRIAL_LAST = ACQ_CYCLES + RES_W - 1;
    localparam int LOAD_AT    = FRAME_CYCLES - 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (go_i && !busy_o) begin
            busy_o <= 1'b1;
            cnt    <= '0;
        end else if (busy_o) begin
            if (cnt == CNT_W'(LOAD_AT)) begin
                busy_o <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        step_o        = '0;
        step_o.init   = busy_o && (cnt == CNT_W'(ACQ_CYCLES - 1));
        step_o.decide = busy_o && (cnt >= CNT_W'(ACQ_CYCLES)) && (cnt <= CNT_W'(TRIAL_LAST));
        step_o.idx    = IDX_W'(TRIAL_LAST - int'(cnt));
        step_o.load   = busy_o && (cnt == CNT_W'(LOAD_AT));
    end

    always_comb begin
        if (!busy_o)
            phase_o = PH_IDLE;
        else if (cnt < CNT_W'(ACQ_CYCLES))
            phase_o = PH_ACQ;
        else if (cnt <= CNT_W'(TRIAL_LAST))
            phase_o = PH_TRIAL;
        else
            phase_o = PH_PAD;
    end

    // R4: the frame ends on the load edge
    a_r4_frame_end: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt == CNT_W'(LOAD_AT) && !abort_i) |=> !busy_o);

    // R4: a running frame advances by one every cycle
    a_r4_frame_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt != CNT_W'(LOAD_AT) && !abort_i) |=> (busy_o && cnt == $past(cnt) + CNT_W'(1)));

    // R8: abort always leaves the timer idle
    a_r8_timer_idle: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !busy_o);

endmodule

// File: rtl/sar_chan_sel.sv
module sar_chan_sel
    import sar_seq_pkg::*;
#(
    parameter int LAST_INPUT = 10,
    parameter int TEST_CODE  = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  capture_i,
    input  chan_t chan_i,
    output chan_t mux_sel_o
);

    chan_t mapped;

    assign mapped = map_chan(chan_i, CHAN_W'(LAST_INPUT), CHAN_W'(TEST_CODE));

    always_ff @(posedge clk) begin
        if (rst)
            mux_sel_o <= '0;
        else if (capture_i)
            mux_sel_o <= mapped;
    end

    // R3: select never points past the test level
    a_r3_sel_range: assert property (@(posedge clk) disable iff (rst)
        mux_sel_o <= CHAN_W'(TEST_CODE));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  step_t step_i,
    input  logic  cmp_ge_i,
    output code_t trial_o
);

    code_t nxt;

    always_comb begin
        nxt = trial_o;
        if (!cmp_ge_i)
            nxt = nxt & ~bit_mask(step_i.idx);
        if (step_i.idx != '0)
            nxt = nxt | bit_mask(step_i.idx - IDX_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            trial_o <= '0;
        else if (step_i.init)
            trial_o <= bit_mask(IDX_W'(RES_W - 1));
        else if (step_i.decide)
            trial_o <= nxt;
    end

    // R6: the first trial is the mid-scale word
    a_r6_first_trial: assert property (@(posedge clk) disable iff (rst)
        (step_i.init && !clr_i) |=> trial_o == code_t'(1 << (RES_W - 1)));

    // R6: keeping a bit never lowers the trial word
    a_r6_keep_up: assert property (@(posedge clk) disable iff (rst)
        (step_i.decide && cmp_ge_i && !clr_i) |=> trial_o >= $past(trial_o));

    // R6: rejecting a bit always lowers the trial word
    a_r6_drop_down: assert property (@(posedge clk) disable iff (rst)
        (step_i.decide && !cmp_ge_i && !clr_i) |=> trial_o < $past(trial_o));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int ACQ_CYCLES   = 2,
    parameter int FRAME_CYCLES = 20,
    parameter int LAST_INPUT   = 10,
    parameter int TEST_CODE    = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [3:0]  chan_i,
    input  logic        abort_i,
    input  logic        cmp_ge_i,
    output logic [3:0]  mux_sel_o,
    output logic        track_o,
    output logic [7:0]  trial_o,
    output logic [7:0]  result_o,
    output logic        eoc_o
);

    logic   busy;
    logic   go;
    phase_e phase;
    step_t  step;
    code_t  trial;
    chan_t  sel;

    assign go = start_i && !busy && !abort_i;

    sar_frame_timer #(
        .ACQ_CYCLES  (ACQ_CYCLES),
        .FRAME_CYCLES(FRAME_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .abort_i(abort_i),
        .busy_o (busy),
        .phase_o(phase),
        .step_o (step)
    );

    sar_chan_sel #(
        .LAST_INPUT(LAST_INPUT),
        .TEST_CODE (TEST_CODE)
    ) chan_i_sel (
        .clk      (clk),
        .rst      (rst),
        .capture_i(go),
        .chan_i   (chan_i),
        .mux_sel_o(sel)
    );

    sar_trial_reg trial_i (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (abort_i),
        .step_i  (step),
        .cmp_ge_i(cmp_ge_i),
        .trial_o (trial)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            eoc_o    <= 1'b1;
        end else if (abort_i) begin
            eoc_o <= 1'b1;
        end else if (go) begin
            eoc_o <= 1'b0;
        end else if (step.load) begin
            result_o <= trial;
            eoc_o    <= 1'b1;
        end
    end

    assign mux_sel_o = sel;
    assign trial_o   = trial;
    assign track_o   = (phase == PH_ACQ);

    // R4: end-of-conversion is low exactly while a frame runs
    a_r4_eoc_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !eoc_o);

    // R8: abort keeps the stored code and raises end-of-conversion
    a_r8_abort_hold: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> ($stable(result_o) && eoc_o));

    // R9: holding register only moves on a load edge
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !step.load |=> $stable(result_o));

    // R7: starts during a frame leave the select alone
    a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(mux_sel_o));

endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [3:0] chan_i;
    logic       abort_i;
    logic       cmp_ge_i;
    logic [3:0] mux_sel_o;
    logic       track_o;
    logic [7:0] trial_o;
    logic [7:0] result_o;
    logic       eoc_o;

    logic [7:0] lvl [16];
    logic [7:0] exp_q [$];
    logic [7:0] model_hold;
    logic [3:0] last_sel;
    logic       eoc_prev;
    logic       done;
    int         checks;
    int         fails;

    always #2 clk = ~clk;

    // behavioural comparator: selected level at or above the trial word
    assign cmp_ge_i = (lvl[mux_sel_o] >= trial_o);

    sar_conv_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .chan_i   (chan_i),
        .abort_i  (abort_i),
        .cmp_ge_i (cmp_ge_i),
        .mux_sel_o(mux_sel_o),
        .track_o  (track_o),
        .trial_o  (trial_o),
        .result_o (result_o),
        .eoc_o    (eoc_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one full conversion, optional start injected at frame cycle inj_at
    task automatic run_conv(input logic [3:0] code, input int inj_at, input logic [3:0] inj_code);
        logic [3:0] esel;
        logic [7:0] eres;
        esel = (code > 4'd10) ? 4'd11 : code;
        eres = lvl[esel];
        exp_q.push_back(eres);
        @(negedge clk);
        start_i = 1'b1;
        chan_i  = code;
        @(negedge clk);
        start_i = 1'b0;
        chk("R4 eoc low after start", {7'd0, eoc_o}, 8'd0);
        chk((code > 4'd10) ? "R3 test select" : "R2 select", {4'd0, mux_sel_o}, {4'd0, esel});
        chk("R6 track cycle 0", {7'd0, track_o}, 8'd1);
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (j == inj_at) begin
                start_i = 1'b1;
                chan_i  = inj_code;
            end
            if (j == inj_at + 1)
                start_i = 1'b0;
            if (j == 1) chk("R6 track cycle 1", {7'd0, track_o}, 8'd1);
            if (j == 2) begin
                chk("R6 track off", {7'd0, track_o}, 8'd0);
                chk("R6 first trial", trial_o, 8'h80);
            end
            if (j == 3) chk("R6 second trial", trial_o, (eres & 8'h80) | 8'h40);
            if (j == 19) chk("R4 eoc still low", {7'd0, eoc_o}, 8'd0);
            if (j == 20) begin
                chk("R4 eoc high at frame end", {7'd0, eoc_o}, 8'd1);
                if (inj_at > 0) chk("R7 select kept", {4'd0, mux_sel_o}, {4'd0, esel});
            end
        end
        model_hold = eres;
        last_sel   = esel;
        @(negedge clk);
        chk("R9 result held", result_o, model_hold);
    endtask

    task automatic abort_conv(input logic [3:0] code, input int after);
        exp_q.push_back(model_hold);
        @(negedge clk);
        start_i = 1'b1;
        chan_i  = code;
        @(negedge clk);
        start_i = 1'b0;
        last_sel = (code > 4'd10) ? 4'd11 : code;
        repeat (after) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk("R8 eoc after abort", {7'd0, eoc_o}, 8'd1);
        chk("R8 trial cleared", trial_o, 8'd0);
        chk("R8 result kept", result_o, model_hold);
        repeat (25) @(negedge clk);
        chk("R9 result after abort", result_o, model_hold);
        chk("R8 stays idle", {7'd0, eoc_o}, 8'd1);
    endtask

    // monitor: compare holding register whenever end-of-conversion rises
    always @(negedge clk) begin
        if (rst) begin
            eoc_prev <= 1'b1;
        end else begin
            if (eoc_prev === 1'b0 && eoc_o === 1'b1) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R5 unexpected eoc rise actual=%h expected=none", result_o);
                end else begin
                    chk("R5 converted code", result_o, exp_q.pop_front());
                end
            end
            eoc_prev <= eoc_o;
        end
    end

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        for (int i = 0; i < 16; i++) lvl[i] = 8'h00;
        lvl[0] = 8'h00; lvl[1] = 8'hFF; lvl[2] = 8'h5A; lvl[3] = 8'hA5;
        lvl[4] = 8'h7F; lvl[5] = 8'h81; lvl[10] = 8'h01; lvl[11] = 8'h80;
        rst = 1'b1; start_i = 1'b0; abort_i = 1'b0; chan_i = 4'd0;
        model_hold = 8'h00; last_sel = 4'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset eoc", {7'd0, eoc_o}, 8'd1);
        chk("R1 reset result", result_o, 8'd0);
        chk("R1 reset trial", trial_o, 8'd0);
        chk("R1 reset select", {4'd0, mux_sel_o}, 8'd0);
        chk("R1 reset track", {7'd0, track_o}, 8'd0);

        run_conv(4'd1, 0, 4'd0);    // full scale
        run_conv(4'd0, 0, 4'd0);    // zero
        run_conv(4'd2, 0, 4'd0);
        run_conv(4'd3, 5, 4'd1);    // R7 mid-frame start
        run_conv(4'd11, 0, 4'd0);   // R3 test level
        run_conv(4'd14, 19, 4'd2);  // R3 out-of-range code, R7 last-cycle start
        run_conv(4'd10, 0, 4'd0);
        run_conv(4'd4, 0, 4'd0);
        run_conv(4'd5, 0, 4'd0);
        abort_conv(4'd1, 6);        // R8 mid-trial abort
        abort_conv(4'd2, 0);        // R8 abort during tracking

        // R8: abort together with start
        @(negedge clk);
        start_i = 1'b1; abort_i = 1'b1; chan_i = 4'd3;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        chk("R8 abort beats start eoc", {7'd0, eoc_o}, 8'd1);
        chk("R8 abort beats start select", {4'd0, mux_sel_o}, {4'd0, last_sel});
        repeat (3) @(negedge clk);
        chk("R8 no frame started", trial_o, 8'd0);

        run_conv(4'd2, 0, 4'd0);    // restart is clean after abort
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R4 missing eoc actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule